// File: doc/BRIEF.md
# Disk Interface Interrupt Request Controller

This block owns the device-to-host interrupt line of a parallel disk interface. The command engine raises a one-cycle request when the device needs attention, and the block stores it as a pending interrupt. A fixed group of events removes the pending interrupt:

- hardware reset
- the soft-reset bit of the device control register
- a host write to the command register
- a host read of the status register
- the end of a sector data transfer

The register decoder is outside this block. It supplies the decoded access strobes as single-cycle pulses.

The pin is driven only while the device is selected and interrupts are enabled. At all other times the output enable is low, so the pad floats. The disable bit acts only on the output enable. A pending interrupt stays stored while the pin is disabled and shows up again once the pin is enabled.

A command-register write clears the interrupt, and the command it starts can raise a new interrupt in the same cycle. To keep that new request from being lost, it is held for one cycle and applied on the next clock edge.

Top module: `irq_ctl`

## Requirements
- R1: `rst_ni` low clears the pending interrupt and any deferred request asynchronously. While `rst_ni` is low, `irq_o` is 0.
- R2: `soft_rst_i` high at a clock edge clears the pending interrupt at that edge. It also discards a request that arrives with a command write in the same cycle.
- R3: A `cmd_wr_i` pulse clears the pending interrupt at the next clock edge.
- R4: A `stat_rd_i` pulse clears the pending interrupt at the next clock edge.
- R5: An `xfer_done_i` pulse clears the pending interrupt at the next clock edge, whether or not the status register was read.
- R6: `irq_oe_o` is 1 only when `dev_sel_i` is 1 and `irq_dis_i` is 0, with no clock delay. While `irq_oe_o` is 0, `irq_o` is 0.
- R7: An `irq_set_i` pulse with no clear event in the same cycle sets the pending interrupt at the next edge. While enabled, `irq_o` is 1 (active high).
- R8: If `irq_set_i` coincides with `stat_rd_i`, `xfer_done_i` or `soft_rst_i`, the clear wins and the request is lost.
- R9: If `irq_set_i` coincides with `cmd_wr_i` (and `soft_rst_i` is low), the first edge leaves the interrupt clear. The second edge sets it, unless a clear event is present at that second edge.
- R10: An `alt_stat_rd_i` pulse has no effect on the pending interrupt.
- R11: `irq_dis_i` changes only the output enable. A pending interrupt survives a disabled interval and drives `irq_o` high again once the pin is re-enabled.
- R12: With no set or clear event, the pending state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hardware reset, active low, asynchronous |
| irq_set_i | input | 1 | Interrupt request pulse from the command engine |
| cmd_wr_i | input | 1 | Command register write strobe |
| stat_rd_i | input | 1 | Status register read strobe |
| alt_stat_rd_i | input | 1 | Alternate status register read strobe |
| soft_rst_i | input | 1 | Soft-reset bit of the device control register |
| xfer_done_i | input | 1 | Sector data transfer complete pulse |
| dev_sel_i | input | 1 | Device-select match |
| irq_dis_i | input | 1 | Interrupt disable bit |
| irq_o | output | 1 | Interrupt level, active high |
| irq_oe_o | output | 1 | Output enable for the interrupt pad |

## Verification
Set and clear events reach `irq_o` one edge after the strobe. A request deferred by a command write reaches it two edges after the strobe. `irq_oe_o` and its masking of `irq_o` follow `dev_sel_i` and `irq_dis_i` within the same cycle, and hardware reset acts with no edge at all. The bench therefore drives every input on the falling edge and samples one time unit after the next rising edge. A result that should take two edges is checked on the row after the stimulus, and the asynchronous reset is checked before any clock edge occurs.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  typedef enum logic [1:0] {
    CLR_CMD  = 2'd0,
    CLR_STAT = 2'd1,
    CLR_SRST = 2'd2,
    CLR_XFER = 2'd3
  } clr_src_e;

  localparam int unsigned NUM_CLR = 4;

  typedef struct packed {
    logic cmd_wr;
    logic stat_rd;
    logic soft_rst;
    logic xfer_done;
  } host_evt_t;
endpackage

// File: rtl/irq_clr_dec.sv
module irq_clr_dec
  import irq_ctl_pkg::*;
(
  input  host_evt_t evt_i,
  input  logic      irq_set_i,
  output logic      clr_any_o,
  output logic      defer_hit_o
);
  logic [NUM_CLR-1:0] clr_vec;

  always_comb begin
    clr_vec           = '0;
    clr_vec[CLR_CMD]  = evt_i.cmd_wr;
    clr_vec[CLR_STAT] = evt_i.stat_rd;
    clr_vec[CLR_SRST] = evt_i.soft_rst;
    clr_vec[CLR_XFER] = evt_i.xfer_done;
  end

  assign clr_any_o   = |clr_vec;
  // request raised by the command just written; soft reset discards it
  assign defer_hit_o = irq_set_i & evt_i.cmd_wr & ~evt_i.soft_rst;
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter bit DEFER_CMD_SET = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_set_i,
  input  logic defer_hit_i,
  input  logic clr_any_i,
  output logic pend_o
);
  logic pend_q;
  logic set_now;

  if (DEFER_CMD_SET) begin : g_defer
    logic dly_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dly_q <= 1'b0;
      else         dly_q <= defer_hit_i;
    end
    assign set_now = irq_set_i | dly_q;
  end else begin : g_nodefer
    logic unused_defer;
    assign unused_defer = defer_hit_i;
    assign set_now      = irq_set_i;
  end

  // clear wins over a set in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (clr_any_i) pend_q <= 1'b0;
    else if (set_now)   pend_q <= 1'b1;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_drv.sv
module irq_drv (
  input  logic pend_i,
  input  logic dev_sel_i,
  input  logic irq_dis_i,
  output logic irq_o,
  output logic irq_oe_o
);
  logic oe;

  assign oe       = dev_sel_i & ~irq_dis_i;
  assign irq_oe_o = oe;
  assign irq_o    = pend_i & oe;
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import irq_ctl_pkg::*;
#(
  parameter bit DEFER_CMD_SET = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_set_i,
  input  logic cmd_wr_i,
  input  logic stat_rd_i,
  input  logic alt_stat_rd_i,
  input  logic soft_rst_i,
  input  logic xfer_done_i,
  input  logic dev_sel_i,
  input  logic irq_dis_i,
  output logic irq_o,
  output logic irq_oe_o
);
  host_evt_t evt;
  logic      clr_any;
  logic      defer_hit;
  logic      pend_q;
  logic      unused_alt;

  // alternate status read deliberately leaves the interrupt alone
  assign unused_alt = alt_stat_rd_i;

  assign evt.cmd_wr    = cmd_wr_i;
  assign evt.stat_rd   = stat_rd_i;
  assign evt.soft_rst  = soft_rst_i;
  assign evt.xfer_done = xfer_done_i;

  irq_clr_dec u_clr_dec (
    .evt_i       (evt),
    .irq_set_i   (irq_set_i),
    .clr_any_o   (clr_any),
    .defer_hit_o (defer_hit)
  );

  irq_pend_reg #(
    .DEFER_CMD_SET (DEFER_CMD_SET)
  ) u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_set_i   (irq_set_i),
    .defer_hit_i (defer_hit),
    .clr_any_i   (clr_any),
    .pend_o      (pend_q)
  );

  irq_drv u_drv (
    .pend_i    (pend_q),
    .dev_sel_i (dev_sel_i),
    .irq_dis_i (irq_dis_i),
    .irq_o     (irq_o),
    .irq_oe_o  (irq_oe_o)
  );
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic irq_set_i,
  input logic cmd_wr_i,
  input logic stat_rd_i,
  input logic alt_stat_rd_i,
  input logic soft_rst_i,
  input logic xfer_done_i,
  input logic dev_sel_i,
  input logic irq_dis_i,
  input logic pend_i,
  input logic irq_o,
  input logic irq_oe_o
);
  logic live_q;
  logic any_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  assign any_clr = cmd_wr_i | stat_rd_i | soft_rst_i | xfer_done_i;

  AST_RST_CLR: assert property (@(posedge clk_i) !rst_ni |-> !pend_i); // R1
  AST_SRST_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !pend_i); // R2
  AST_CMD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i |=> !pend_i); // R3
  AST_STAT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> !pend_i); // R4
  AST_XFER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i |=> !pend_i); // R5
  AST_OE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_oe_o |-> !irq_o); // R6
  AST_OE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dev_sel_i || irq_dis_i) |-> !irq_oe_o); // R6
  AST_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_set_i && !any_clr) |=> pend_i); // R7
  AST_DEFER_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(irq_set_i && cmd_wr_i && !soft_rst_i) && !any_clr) |=> pend_i); // R9
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && !any_clr) |=> pend_i); // R10 R11 R12
  AST_IRQ_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && dev_sel_i && !irq_dis_i) |-> irq_o); // R7 R11

  logic unused_alt;
  assign unused_alt = alt_stat_rd_i;
endmodule

bind irq_ctl irq_ctl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .irq_set_i     (irq_set_i),
  .cmd_wr_i      (cmd_wr_i),
  .stat_rd_i     (stat_rd_i),
  .alt_stat_rd_i (alt_stat_rd_i),
  .soft_rst_i    (soft_rst_i),
  .xfer_done_i   (xfer_done_i),
  .dev_sel_i     (dev_sel_i),
  .irq_dis_i     (irq_dis_i),
  .pend_i        (pend_q),
  .irq_o         (irq_o),
  .irq_oe_o      (irq_oe_o)
);

// File: tb/irq_ctl_bench.sv
module irq_ctl_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N_VEC      = 25;
  localparam int unsigned WDOG_LIM   = 5000;

  // {set,cmd,stat,alt,srst,xfer,sel,dis, exp_irq,exp_oe, req[3:0]}
  localparam logic [13:0] VEC [N_VEC] = '{
    14'b0000001_0_0_1_0110, // idle                      R6
    14'b1000001_0_1_1_0111, // set                       R7
    14'b0000001_0_1_1_1100, // hold                      R12
    14'b0001001_0_1_1_1010, // alternate status read     R10
    14'b0010001_0_0_1_0100, // status read clears        R4
    14'b1000001_0_1_1_0111, // set                       R7
    14'b0100001_0_0_1_0011, // command write clears      R3
    14'b1000001_0_1_1_0111, // set                       R7
    14'b0000011_0_0_1_0101, // transfer done clears      R5
    14'b1000001_0_1_1_0111, // set                       R7
    14'b0000101_0_0_1_0010, // soft reset clears         R2
    14'b1010001_0_0_1_1000, // set vs status read        R8
    14'b1100001_0_0_1_1001, // set with command write    R9
    14'b0000001_0_1_1_1001, // deferred set lands        R9
    14'b0000001_1_0_0_1011, // disabled                  R11
    14'b0000001_1_0_0_1011, // still disabled            R11
    14'b0000001_0_1_1_1011, // re-enabled, kept          R11
    14'b0000000_0_0_0_0110, // deselected                R6
    14'b0000001_0_1_1_0110, // selected again            R6
    14'b1100001_0_0_1_1001, // set with command write    R9
    14'b0000011_0_0_1_1001, // clear beats deferred set  R9
    14'b0000001_0_0_1_1100, // hold clear                R12
    14'b1100101_0_0_1_0010, // soft reset drops deferral R2
    14'b0000001_0_0_1_0010, // still clear               R2
    14'b1000011_0_0_1_1000  // set vs transfer done      R8
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic irq_set, cmd_wr, stat_rd, alt_rd, srst, xfer, sel, dis;
  logic irq, oe;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctl u_irq_ctl (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .irq_set_i     (irq_set),
    .cmd_wr_i      (cmd_wr),
    .stat_rd_i     (stat_rd),
    .alt_stat_rd_i (alt_rd),
    .soft_rst_i    (srst),
    .xfer_done_i   (xfer),
    .dev_sel_i     (sel),
    .irq_dis_i     (dis),
    .irq_o         (irq),
    .irq_oe_o      (oe)
  );

  task automatic check(input string req, input logic e_irq, input logic e_oe);
    n_chk++;
    if (irq !== e_irq || oe !== e_oe) begin
      n_bad++;
      $display("FAIL %s: irq=%b oe=%b expected irq=%b oe=%b", req, irq, oe, e_irq, e_oe);
    end
  endtask

  task automatic drive(input logic [7:0] v);
    {irq_set, cmd_wr, stat_rd, alt_rd, srst, xfer, sel, dis} = v;
  endtask

  task automatic step(input logic [7:0] v);
    @(negedge clk);
    drive(v);
    @(posedge clk);
    #1;
  endtask

  initial begin
    drive(8'b0000000_0);
    #(CLK_PERIOD * 2);
    check("R1", 1'b0, 1'b0); // R1 reset state, deselected
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      step(VEC[i][13:6]);
      check($sformatf("R%0d row %0d", VEC[i][3:0], i), VEC[i][5], VEC[i][4]);
    end

    // R1: asynchronous clear without a clock edge
    step(8'b1000001_0);
    check("R7", 1'b1, 1'b1);
    @(negedge clk);
    drive(8'b0000001_0);
    #1;
    rst_ni = 1'b0;
    #1;
    check("R1", 1'b0, 1'b1);
    @(negedge clk);
    rst_ni = 1'b1;
    step(8'b0000001_0);
    check("R1", 1'b0, 1'b1);

    // R1: a deferred request is discarded by hardware reset
    step(8'b1100001_0);
    @(negedge clk);
    drive(8'b0000001_0);
    rst_ni = 1'b0;
    #1;
    rst_ni = 1'b1;
    @(posedge clk);
    #1;
    check("R1", 1'b0, 1'b1);

    // R11: pending set while disabled shows up on enable
    step(8'b1000001_1);
    check("R11", 1'b0, 1'b0);
    step(8'b0000001_0);
    check("R11", 1'b1, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < WDOG_LIM; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule